// File: doc/BRIEF.md
# Time-of-Day Alarm Matcher

This block decides, on every seconds update of a real-time clock, whether the freshly updated time equals a programmed alarm. It receives the clock's second, minute and hour bytes together with three alarm bytes. All six bytes share one storage format: BCD or binary, and 12-hour or 24-hour for the hour. On each update strobe it compares the three fields and latches an alarm flag when they all agree. An alarm byte whose top two bits are both one is a wildcard that agrees with any value of its field. This gives alarms once per second, once per minute, once per hour or once per day.

The block also keeps an update-ended flag that is set on every accepted update. Both flags can be read and are cleared by one clear strobe, which the surrounding register logic issues when software reads the status. A one-cycle pulse marks each cycle in which the alarm flag newly turns on, so an interrupt stage can use it as an edge. The timekeeping counters and the interrupt routing are outside this block.

Top module: `rtc_alarm_match`

## Requirements
- R1: After a synchronous active-low reset, `upd_flag`, `alarm_flag` and `alarm_new` are all 0.
- R2: A cycle with `upd_tick`=1 and `set_hold`=0 is an update. It sets `upd_flag` on the next cycle, whether or not the alarm matches.
- R3: On an update where all three fields match, `alarm_flag` and `alarm_new` go to 1 on the next cycle, in the same cycle as `upd_flag`. `alarm_new` lasts exactly one cycle.
- R4: If any one non-wildcard field differs from the current time, the update leaves `alarm_flag` at 0.
- R5: An alarm byte with bits [7:6] = 2'b11 is a wildcard and matches every value of its field.
- R6: With all three alarm bytes wildcards, every update sets `alarm_flag`.
- R7: With `bin_mode`=0, bytes are decoded as two BCD digits (upper nibble is tens, lower nibble is units). With `bin_mode`=1, the byte is the value itself. Example: in 12-hour mode the hour byte 8'h10 equals alarm hour 8'h04 in binary, but not in BCD.
- R8: With `hr24_mode`=0, both the clock hour and the alarm hour are converted to 0..23 before they are compared. The conversion decodes bits [6:0], reduces the result modulo 12, and adds 12 when bit 7 (PM) is 1. So 8'h12 (12 AM) equals 0 and 8'h81 (1 PM) equals 13.
- R9: With `hr24_mode`=1, bit 7 of an hour byte is part of the value and not a PM marker.
- R10: An update that matches while `alarm_flag` is already 1 and no clear is applied keeps the flag at 1 and does not pulse `alarm_new`.
- R11: While `set_hold`=1, `upd_tick` is ignored: neither flag is set.
- R12: `flag_clear` clears both flags on the next cycle. If a clear and a matching update fall in the same cycle, the update wins: both flags read 1 and `alarm_new` pulses.
- R13: The alarm bytes are sampled only at an update. Changing them between updates does not change `alarm_flag` until the next update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_tick | input | 1 | One-cycle strobe; the time bytes already hold the new second |
| set_hold | input | 1 | Time-setting hold; updates are suppressed |
| flag_clear | input | 1 | Clears both status flags (status read) |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24_mode | input | 1 | 1 = 24-hour hour bytes, 0 = 12-hour with PM in bit 7 |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_hour | input | 8 | Alarm hours byte |
| upd_flag | output | 1 | Update-ended flag |
| alarm_flag | output | 1 | Alarm flag |
| alarm_new | output | 1 | One-cycle pulse when `alarm_flag` newly turns on |

## Verification
A matching update and a status clear can arrive in the same cycle, and the block must then keep the new event rather than lose it. The bench first latches the alarm flag. It then raises `upd_tick` and `flag_clear` together with all-wildcard alarm bytes. It expects both flags to read 1 and `alarm_new` to pulse on the next cycle. A clear alone on the following cycle must then drop both flags. The same collision is also judged with a non-matching alarm: `upd_flag` must survive and `alarm_flag` must fall.

// File: rtl/rtc_alarm_pkg.sv
// Package rtc_alarm_pkg
// Shared widths and the byte-to-value decoding used by every field comparator.
// Assumes valid clock bytes: 12-hour values lie in 1..12 (so a single
// subtraction performs the modulo-12 step).
package rtc_alarm_pkg;
    localparam int BYTE_W     = 8;
    localparam int NUM_FIELDS = 3;
    localparam int HOUR_IDX   = 2;

    typedef logic [BYTE_W-1:0] tbyte_t;

    // Two BCD digits to a binary value.
    function automatic tbyte_t bcd_to_bin(input tbyte_t b);
        tbyte_t hi;
        hi = {4'd0, b[7:4]};
        return (hi << 3) + (hi << 1) + {4'd0, b[3:0]};
    endfunction

    // Decode one field byte into a comparable value.
    function automatic tbyte_t field_value(input tbyte_t b, input logic bin,
                                           input logic is_hour, input logic hr24);
        tbyte_t raw;
        tbyte_t v;
        raw = (is_hour && !hr24) ? {1'b0, b[6:0]} : b;
        v   = bin ? raw : bcd_to_bin(raw);
        if (is_hour && !hr24) begin
            if (v >= 8'd12) v = v - 8'd12;
            if (b[7])       v = v + 8'd12;
        end
        return v;
    endfunction
endpackage

// File: rtl/rtc_alarm_field.sv
// Module rtc_alarm_field
// Compares one time field against its alarm byte. The alarm byte acts as a
// wildcard when its two top bits are set. IS_HOUR selects hour handling
// (12-hour conversion of both bytes).
module rtc_alarm_field
    import rtc_alarm_pkg::*;
#(
    parameter bit IS_HOUR = 1'b0
) (
    input  tbyte_t cur_byte,
    input  tbyte_t alm_byte,
    input  logic   bin_mode,
    input  logic   hr24_mode,
    output logic   hit
);
    tbyte_t cur_val;
    tbyte_t alm_val;
    logic   wild;

    // decode both bytes and form the per-field match
    always_comb begin
        wild    = (alm_byte[7:6] == 2'b11);
        cur_val = field_value(cur_byte, bin_mode, IS_HOUR, hr24_mode);
        alm_val = field_value(alm_byte, bin_mode, IS_HOUR, hr24_mode);
        hit     = wild || (cur_val == alm_val);
    end
endmodule

// File: rtl/rtc_alarm_flags.sv
// Module rtc_alarm_flags
// Holds the update-ended and alarm flags. It qualifies the update strobe with
// the time-setting hold. A same-cycle clear loses to a new event.
module rtc_alarm_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_tick,
    input  logic set_hold,
    input  logic flag_clear,
    input  logic all_hit,
    output logic upd_flag,
    output logic alarm_flag,
    output logic alarm_new
);
    logic upd_ev;
    logic alm_ev;

    // qualify the update and the alarm event
    always_comb begin
        upd_ev = upd_tick && !set_hold;
        alm_ev = upd_ev && all_hit;
    end

    // flag registers with set-over-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_flag   <= 1'b0;
            alarm_flag <= 1'b0;
            alarm_new  <= 1'b0;
        end else begin
            if (upd_ev)          upd_flag <= 1'b1;
            else if (flag_clear) upd_flag <= 1'b0;
            if (alm_ev)          alarm_flag <= 1'b1;
            else if (flag_clear) alarm_flag <= 1'b0;
            alarm_new <= alm_ev && (!alarm_flag || flag_clear);
        end
    end

    // R3
    af_with_uf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> upd_flag);
    // R11
    hold_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_tick && set_hold && !flag_clear) |=> ($stable(upd_flag) && $stable(alarm_flag)));
    // R12
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clear && !upd_tick) |=> (!upd_flag && !alarm_flag));
    // R3
    new_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_new |-> alarm_flag);
    // R2
    af_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(upd_tick && !set_hold));
endmodule

// File: rtl/rtc_alarm_match.sv
// Module rtc_alarm_match
// Top level: one comparator per time field, built in a generate loop, feeding
// the flag register. The time bytes must already hold the updated second in
// the cycle in which upd_tick is high.
module rtc_alarm_match
    import rtc_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd_tick,
    input  logic       set_hold,
    input  logic       flag_clear,
    input  logic       bin_mode,
    input  logic       hr24_mode,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic [7:0] alm_sec,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    output logic       upd_flag,
    output logic       alarm_flag,
    output logic       alarm_new
);
    tbyte_t cur_arr [NUM_FIELDS];
    tbyte_t alm_arr [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] hits;
    logic all_hit;

    // gather field bytes into indexed arrays
    always_comb begin
        cur_arr[0] = cur_sec;  alm_arr[0] = alm_sec;
        cur_arr[1] = cur_min;  alm_arr[1] = alm_min;
        cur_arr[2] = cur_hour; alm_arr[2] = alm_hour;
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        rtc_alarm_field #(.IS_HOUR(g == HOUR_IDX)) u_field (
            .cur_byte (cur_arr[g]),
            .alm_byte (alm_arr[g]),
            .bin_mode (bin_mode),
            .hr24_mode(hr24_mode),
            .hit      (hits[g])
        );
    end

    // all fields must agree
    assign all_hit = &hits;

    rtc_alarm_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_tick  (upd_tick),
        .set_hold  (set_hold),
        .flag_clear(flag_clear),
        .all_hit   (all_hit),
        .upd_flag  (upd_flag),
        .alarm_flag(alarm_flag),
        .alarm_new (alarm_new)
    );

    // R6
    all_wild_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_tick && !set_hold && alm_sec[7:6] == 2'b11 && alm_min[7:6] == 2'b11
         && alm_hour[7:6] == 2'b11) |=> alarm_flag);
endmodule

// File: tb/rtc_alarm_match_bench.sv
module rtc_alarm_match_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic upd_tick = 1'b0, set_hold = 1'b0, flag_clear = 1'b0;
    logic bin_mode = 1'b0, hr24_mode = 1'b1;
    logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00;
    logic [7:0] alm_sec = 8'h00, alm_min = 8'h00, alm_hour = 8'h00;
    logic upd_flag, alarm_flag, alarm_new;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtc_alarm_match u_rtc_alarm_match (.*);

    // {bin, hr24, exp_af, cs, cm, ch, as, am, ah}
    localparam int NV = 14;
    localparam logic [50:0] VEC [NV] = '{
        {1'b0,1'b1,1'b1, 8'h56,8'h34,8'h12, 8'h56,8'h34,8'h12}, // R3 exact
        {1'b0,1'b1,1'b0, 8'h56,8'h34,8'h12, 8'h57,8'h34,8'h12}, // R4 sec
        {1'b0,1'b1,1'b0, 8'h56,8'h34,8'h12, 8'h56,8'h35,8'h12}, // R4 min
        {1'b0,1'b1,1'b0, 8'h56,8'h34,8'h12, 8'h56,8'h34,8'h13}, // R4 hour
        {1'b0,1'b1,1'b1, 8'h07,8'h34,8'h12, 8'hC0,8'h34,8'h12}, // R5 sec wild
        {1'b0,1'b1,1'b1, 8'h20,8'h10,8'h05, 8'h20,8'h10,8'hFF}, // R5 hour wild
        {1'b0,1'b1,1'b1, 8'h41,8'h27,8'h19, 8'hFF,8'hC3,8'hD9}, // R6 all wild
        {1'b0,1'b0,1'b1, 8'h00,8'h00,8'h81, 8'h00,8'h00,8'h81}, // R8 1 PM
        {1'b0,1'b0,1'b0, 8'h00,8'h00,8'h01, 8'h00,8'h00,8'h81}, // R8 AM vs PM
        {1'b0,1'b0,1'b1, 8'h00,8'h00,8'h12, 8'h00,8'h00,8'h00}, // R8 12 AM = 0
        {1'b1,1'b0,1'b1, 8'h00,8'h00,8'h10, 8'h00,8'h00,8'h04}, // R7 binary 16 -> 4
        {1'b0,1'b0,1'b0, 8'h00,8'h00,8'h10, 8'h00,8'h00,8'h04}, // R7 BCD 10
        {1'b0,1'b1,1'b0, 8'h00,8'h00,8'h81, 8'h00,8'h00,8'h01}, // R9 bit7 is value
        {1'b1,1'b1,1'b1, 8'h3B,8'h2A,8'h17, 8'h3B,8'h2A,8'h17}  // R7 binary 24h
    };

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_update(input logic clr);
        @(negedge clk); upd_tick = 1'b1; flag_clear = clr;
        @(negedge clk); upd_tick = 1'b0; flag_clear = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk); flag_clear = 1'b1;
        @(negedge clk); flag_clear = 1'b0;
    endtask

    task automatic set_all_wild();
        alm_sec = 8'hFF; alm_min = 8'hFF; alm_hour = 8'hFF;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 uf", upd_flag, 1'b0);
        chk("R1 af", alarm_flag, 1'b0);
        chk("R1 new", alarm_new, 1'b0);

        for (int i = 0; i < NV; i++) begin
            do_clear();
            {bin_mode, hr24_mode} = VEC[i][50:49];
            {cur_sec, cur_min, cur_hour, alm_sec, alm_min, alm_hour} = VEC[i][47:0];
            do_update(1'b0);
            chk($sformatf("R2 uf vec%0d", i), upd_flag, 1'b1);
            chk($sformatf("R3 af vec%0d", i), alarm_flag, VEC[i][48]);
            chk($sformatf("R3 new vec%0d", i), alarm_new, VEC[i][48]);
            @(negedge clk);
            chk($sformatf("R3 new width vec%0d", i), alarm_new, 1'b0);
        end

        // R10: match while already set
        bin_mode = 1'b0; hr24_mode = 1'b1;
        do_clear();
        set_all_wild();
        do_update(1'b0);
        chk("R6 af", alarm_flag, 1'b1);
        do_update(1'b0);
        chk("R10 af stays", alarm_flag, 1'b1);
        chk("R10 no new", alarm_new, 1'b0);

        // R12: clear and matching update in the same cycle
        do_update(1'b1);
        chk("R12 uf wins", upd_flag, 1'b1);
        chk("R12 af wins", alarm_flag, 1'b1);
        chk("R12 new", alarm_new, 1'b1);
        do_clear();
        chk("R12 uf cleared", upd_flag, 1'b0);
        chk("R12 af cleared", alarm_flag, 1'b0);
        // R12: clear with non-matching update: af falls, uf set
        do_update(1'b0);
        alm_sec = 8'h01; cur_sec = 8'h02;
        do_update(1'b1);
        chk("R12 nomatch uf", upd_flag, 1'b1);
        chk("R12 nomatch af", alarm_flag, 1'b0);

        // R11: hold blocks updates
        do_clear();
        set_all_wild();
        set_hold = 1'b1;
        do_update(1'b0);
        chk("R11 uf", upd_flag, 1'b0);
        chk("R11 af", alarm_flag, 1'b0);
        set_hold = 1'b0;

        // R13: alarm change acts only at next update
        cur_sec = 8'h10; cur_min = 8'h20; cur_hour = 8'h08;
        alm_sec = 8'h11; alm_min = 8'h20; alm_hour = 8'h08;
        do_update(1'b0);
        chk("R13 no match", alarm_flag, 1'b0);
        @(negedge clk); alm_sec = 8'h10;
        repeat (2) @(negedge clk);
        chk("R13 no effect yet", alarm_flag, 1'b0);
        do_update(1'b0);
        chk("R13 match at update", alarm_flag, 1'b1);

        // R1: reset clears set flags
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 uf after reset", upd_flag, 1'b0);
        chk("R1 af after reset", alarm_flag, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule